// File: doc/BRIEF.md
# Single-Access SDRAM Controller

This block sits between a simple host port and a 16-bit SDR SDRAM of 32 MB. It runs at 100 MHz. After reset it waits out the power-up interval on NOP commands. It then brings the device up with a precharge of every bank, two auto-refresh commands and a mode-register load. After that it parks in an idle state.

From idle it serves three kinds of work, checked in this order:
- a pending refresh;
- a read request;
- a write request.

Each access opens one row with an activate. It then issues one column command with auto-precharge set, so no row is ever left open between accesses. A refresh timer raises a request evenly, about every 390 clocks (8192 per 32 ms). Each refresh is a precharge-all followed by one auto-refresh.

The host presents a 24-bit address and, for writes, 16 bits of data, then raises an enable. It drops the enable once `busy` is seen. Read data arrives with a one-cycle `rd_ready` pulse.

Top module: `sdram_ctrl_top`

## Requirements
- R1: While reset is high the bus carries NOP, with `sd_cke` low and `busy` and `rd_ready` low. The command code is {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACT 0011, READ 0101, WRITE 0100, PRE 0010, REF 0001, MRS 0000. After reset falls, the bus carries only NOP for at least POWERUP_CYC clocks, and `sd_cke` goes high.
- R2: The first four non-NOP commands are, in order, PRE with addr[10]=1, REF, REF, and MRS with bank 0 and addr = 0x230. The value 0x230 means burst length 1 in bits 2:0, sequential type in bit 3, CAS latency 3 in bits 6:4, and single-location writes in bit 9.
- R3: A host address splits as bank = [23:22], row = [21:9], column = [8:0]. ACT carries the bank on `sd_ba` and the row on `sd_addr`. READ and WRITE carry the bank, the column in `sd_addr[8:0]` and addr[10]=1.
- R4: A write issues ACT and then WRITE. The write data is on `sd_dq` in the WRITE cycle, with both byte masks low. The controller drives `sd_dq` in no other cycle.
- R5: A read issues ACT and then READ. The word on `sd_dq` CAS_LAT cycles after READ reaches `rd_data` in the cycle in which `rd_ready` is high. `rd_ready` is a single-cycle pulse, exactly one per read.
- R6: `busy` rises on the clock edge that accepts a request. It stays high for T_RCD+T_WRP+2 cycles for a write (8 by default) and T_RCD+CAS_LAT+4 cycles for a read (9 by default). The `rd_ready` pulse falls inside the read's busy window.
- R7: Address and data are captured when the request is accepted. Changing `wr_addr` or `wr_data` while `busy` is high has no effect on the access in flight.
- R8: An enable still high when the controller returns to idle is taken as a new request.
- R9: When `rd_en` and `wr_en` are both high in idle, the read is served and the write is not.
- R10: Every refresh after initialisation is a PRE with addr[10]=1 followed by REF. Consecutive refreshes are spaced REFRESH_INTERVAL clocks apart, within ±20 clocks.
- R11: A due refresh wins over a pending read or write in idle. Refreshes keep their spacing while the host requests back-to-back without a gap.
- R12: Device timing holds:
  - REF and ACT come no sooner than 2 clocks after a PRE.
  - READ and WRITE come at least 2 clocks after the ACT of their bank, and only to an open bank.
  - Two ACTs to the same bank are at least 7 clocks apart.
  - REF finds all banks closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr | input | 24 | Write address {bank,row,column} |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write request |
| rd_addr | input | 24 | Read address {bank,row,column} |
| rd_en | input | 1 | Read request |
| rd_data | output | 16 | Read data, valid with rd_ready |
| rd_ready | output | 1 | One-cycle read data strobe |
| busy | output | 1 | Access accepted and in progress |
| sd_addr | output | 13 | SDRAM address |
| sd_ba | output | 2 | SDRAM bank address |
| sd_dq | inout | 16 | SDRAM data |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm_lo | output | 1 | Low byte mask |
| sd_dqm_hi | output | 1 | High byte mask |

## Verification
The assertions assume the host follows the enable handshake: an enable stays high until `busy` is seen, and is dropped afterwards unless a further request is intended. They also assume the memory drives `sd_dq` only in the read-data slot. The bench keeps to both conditions. Its tasks raise an enable and lower it on the first cycle `busy` reads high. Only the deliberate re-request and back-to-back cases hold it longer. The memory model in the bench drives the bus for exactly one cycle, CAS_LAT cycles after each READ it decodes.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int BANK_W    = 2;
    localparam int ROW_W     = 13;
    localparam int COL_W     = 9;
    localparam int DATA_W    = 16;
    localparam int HOST_AW   = BANK_W + ROW_W + COL_W;
    localparam int SD_AW     = ROW_W;
    localparam int AP_BIT    = 10;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_IPRE,
        ST_IREF1,
        ST_IREF2,
        ST_IMRS,
        ST_IDLE,
        ST_RPRE,
        ST_RREF,
        ST_ACT,
        ST_RD,
        ST_WR,
        ST_WAIT
    } state_e;

    typedef struct packed {
        logic              is_rd;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] data;
    } req_t;

    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] ba;
        logic [SD_AW-1:0]  a;
        logic              oe;
        logic [DATA_W-1:0] dout;
        logic              mask;
    } bus_t;

    function automatic logic [SD_AW-1:0] mode_word(input int cas);
        logic [SD_AW-1:0] w;
        w      = '0;
        w[2:0] = 3'b000;      // one word per access
        w[3]   = 1'b0;        // sequential ordering
        w[6:4] = cas[2:0];    // read latency
        w[9]   = 1'b1;        // writes touch one location
        return w;
    endfunction

    function automatic req_t make_req(input logic rd,
                                      input logic [HOST_AW-1:0] addr,
                                      input logic [DATA_W-1:0] d);
        req_t r;
        r.is_rd = rd;
        r.bank  = addr[HOST_AW-1 -: BANK_W];
        r.row   = addr[COL_W +: ROW_W];
        r.col   = addr[COL_W-1:0];
        r.data  = d;
        return r;
    endfunction

    function automatic logic [SD_AW-1:0] col_word(input logic [COL_W-1:0] c);
        logic [SD_AW-1:0] w;
        w            = '0;
        w[COL_W-1:0] = c;
        w[AP_BIT]    = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
    parameter int INTERVAL = 390
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= CW'(INTERVAL - 1);
            pending <= 1'b0;
        end else begin
            cnt <= tick ? CW'(INTERVAL - 1) : cnt - 1'b1;
            if (tick)
                pending <= 1'b1;
            else if (ack)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/sdc_seq.sv
module sdc_seq
    import sdc_pkg::*;
#(
    parameter int POWERUP_CYC = 10000,
    parameter int CAS_LAT     = 3,
    parameter int T_RCD       = 2,
    parameter int T_RP        = 2,
    parameter int T_RC        = 7,
    parameter int T_MRD       = 2,
    parameter int T_WRP       = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [HOST_AW-1:0] rd_addr,
    input  logic [HOST_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               ref_pending,
    output logic               ref_ack,
    output state_e             state,
    output logic               busy,
    output logic               rd_issue,
    output bus_t               nxt
);
    localparam int MAXW   = (POWERUP_CYC > CAS_LAT + 2 + T_RC) ? POWERUP_CYC : CAS_LAT + 2 + T_RC;
    localparam int WAIT_W = $clog2(MAXW + 1) + 1;

    logic [WAIT_W-1:0] wait_cnt;
    state_e            ret;
    req_t              req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_PWRUP;
            ret      <= ST_IPRE;
            wait_cnt <= WAIT_W'(POWERUP_CYC);
            busy     <= 1'b0;
            req      <= '0;
        end else begin
            unique case (state)
                ST_PWRUP: begin
                    if (wait_cnt <= 1) state <= ST_IPRE;
                    else wait_cnt <= wait_cnt - 1'b1;
                end
                ST_IPRE: begin
                    state <= ST_WAIT; ret <= ST_IREF1; wait_cnt <= WAIT_W'(T_RP);
                end
                ST_IREF1: begin
                    state <= ST_WAIT; ret <= ST_IREF2; wait_cnt <= WAIT_W'(T_RC);
                end
                ST_IREF2: begin
                    state <= ST_WAIT; ret <= ST_IMRS; wait_cnt <= WAIT_W'(T_RC);
                end
                ST_IMRS: begin
                    state <= ST_WAIT; ret <= ST_IDLE; wait_cnt <= WAIT_W'(T_MRD);
                end
                ST_IDLE: begin
                    if (ref_pending) begin
                        state <= ST_RPRE;
                    end else if (rd_en) begin
                        req   <= make_req(1'b1, rd_addr, '0);
                        busy  <= 1'b1;
                        state <= ST_ACT;
                    end else if (wr_en) begin
                        req   <= make_req(1'b0, wr_addr, wr_data);
                        busy  <= 1'b1;
                        state <= ST_ACT;
                    end
                end
                ST_RPRE: begin
                    state <= ST_WAIT; ret <= ST_RREF; wait_cnt <= WAIT_W'(T_RP);
                end
                ST_RREF: begin
                    state <= ST_WAIT; ret <= ST_IDLE; wait_cnt <= WAIT_W'(T_RC);
                end
                ST_ACT: begin
                    state    <= ST_WAIT;
                    ret      <= req.is_rd ? ST_RD : ST_WR;
                    wait_cnt <= WAIT_W'(T_RCD);
                end
                ST_RD: begin
                    state <= ST_WAIT; ret <= ST_IDLE; wait_cnt <= WAIT_W'(CAS_LAT + 2);
                end
                ST_WR: begin
                    state <= ST_WAIT; ret <= ST_IDLE; wait_cnt <= WAIT_W'(T_WRP);
                end
                ST_WAIT: begin
                    if (wait_cnt <= 1) begin
                        state <= ret;
                        if (ret == ST_IDLE) busy <= 1'b0;
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ref_ack  = (state == ST_RPRE);
    assign rd_issue = (state == ST_RD);

    always_comb begin
        nxt      = '0;
        nxt.cmd  = CMD_NOP;
        nxt.mask = (state == ST_PWRUP);
        unique case (state)
            ST_IPRE, ST_RPRE: begin
                nxt.cmd       = CMD_PRE;
                nxt.a[AP_BIT] = 1'b1;
            end
            ST_IREF1, ST_IREF2, ST_RREF: nxt.cmd = CMD_REF;
            ST_IMRS: begin
                nxt.cmd = CMD_MRS;
                nxt.a   = mode_word(CAS_LAT);
            end
            ST_ACT: begin
                nxt.cmd = CMD_ACT;
                nxt.ba  = req.bank;
                nxt.a   = req.row;
            end
            ST_RD: begin
                nxt.cmd = CMD_RD;
                nxt.ba  = req.bank;
                nxt.a   = col_word(req.col);
            end
            ST_WR: begin
                nxt.cmd  = CMD_WR;
                nxt.ba   = req.bank;
                nxt.a    = col_word(req.col);
                nxt.oe   = 1'b1;
                nxt.dout = req.data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdc_pins.sv
module sdc_pins
    import sdc_pkg::*;
#(
    parameter int CAS_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_t              nxt,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dq_in,
    output bus_t              cur,
    output logic              cke,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ready
);
    logic [CAS_LAT:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            cur.cmd  <= CMD_NOP;
            cur.mask <= 1'b1;
            cke      <= 1'b0;
            pipe     <= '0;
            rd_data  <= '0;
            rd_ready <= 1'b0;
        end else begin
            cur      <= nxt;
            cke      <= 1'b1;
            pipe     <= {pipe[CAS_LAT-1:0], rd_issue};
            rd_ready <= pipe[CAS_LAT];
            if (pipe[CAS_LAT]) rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_ctrl_top.sv
module sdram_ctrl_top
    import sdc_pkg::*;
#(
    parameter int POWERUP_CYC      = 10000,
    parameter int REFRESH_INTERVAL = 390,
    parameter int CAS_LAT          = 3,
    parameter int T_RCD            = 2,
    parameter int T_RP             = 2,
    parameter int T_RC             = 7,
    parameter int T_MRD            = 2,
    parameter int T_WRP            = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wr_en,
    input  logic [HOST_AW-1:0] rd_addr,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_ready,
    output logic               busy,
    output logic [SD_AW-1:0]   sd_addr,
    output logic [BANK_W-1:0]  sd_ba,
    inout  wire  [DATA_W-1:0]  sd_dq,
    output logic               sd_cke,
    output logic               sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic               sd_dqm_lo,
    output logic               sd_dqm_hi
);
    logic   ref_pend;
    logic   ref_ack;
    logic   rd_issue;
    state_e fsm_state;
    bus_t   bus_nxt;
    bus_t   bus_cur;

    sdc_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) timer_i (
        .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pend)
    );

    sdc_seq #(
        .POWERUP_CYC(POWERUP_CYC), .CAS_LAT(CAS_LAT), .T_RCD(T_RCD),
        .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .T_WRP(T_WRP)
    ) seq_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data(wr_data),
        .ref_pending(ref_pend), .ref_ack(ref_ack), .state(fsm_state),
        .busy(busy), .rd_issue(rd_issue), .nxt(bus_nxt)
    );

    sdc_pins #(.CAS_LAT(CAS_LAT)) pins_i (
        .clk(clk), .rst(rst), .nxt(bus_nxt), .rd_issue(rd_issue),
        .dq_in(sd_dq), .cur(bus_cur), .cke(sd_cke),
        .rd_data(rd_data), .rd_ready(rd_ready)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = bus_cur.cmd;
    assign sd_addr   = bus_cur.a;
    assign sd_ba     = bus_cur.ba;
    assign sd_dqm_lo = bus_cur.mask;
    assign sd_dqm_hi = bus_cur.mask;
    assign sd_dq     = bus_cur.oe ? bus_cur.dout : 'z;
endmodule

// File: rtl/sdram_ctrl_chk.sv
module sdram_ctrl_chk
    import sdc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [3:0]        cmd,
    input logic [SD_AW-1:0]  addr,
    input logic              dq_oe,
    input logic              busy,
    input logic              rd_ready,
    input logic              ref_pend,
    input state_e            state
);
    logic [3:0] last_cmd;

    always_ff @(posedge clk) begin
        if (rst) last_cmd <= CMD_NOP;
        else if (cmd != CMD_NOP) last_cmd <= cmd;
    end

    assert_col_autopre_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_WR) |-> addr[AP_BIT]);

    assert_write_drives_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WR) |-> dq_oe);

    assert_drive_only_write_R4: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (cmd == CMD_WR));

    assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rd_ready |=> !rd_ready);

    assert_ready_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> busy);

    assert_busy_from_idle_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(state) == ST_IDLE));

    assert_ref_after_pre_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REF) |-> (last_cmd == CMD_PRE || last_cmd == CMD_REF));

    assert_refresh_first_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && ref_pend) |=> (state == ST_RPRE));
endmodule

bind sdram_ctrl_top sdram_ctrl_chk chk_i (
    .clk(clk), .rst(rst),
    .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .addr(sd_addr), .dq_oe(bus_cur.oe), .busy(busy), .rd_ready(rd_ready),
    .ref_pend(ref_pend), .state(fsm_state)
);

// File: tb/sdram_ctrl_top_tb_top.sv
module sdram_ctrl_top_tb_top;
    localparam int PWR  = 50;
    localparam int RINT = 390;
    localparam int CASL = 3;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_MRS = 4'b0000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic [23:0] wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        rd_ready, busy;
    logic [12:0] sd_addr;
    logic [1:0]  sd_ba;
    wire  [15:0] sd_dq;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm_lo, sd_dqm_hi;

    logic        m_oe = 1'b0;
    logic [15:0] m_dq = '0;
    assign sd_dq = m_oe ? m_dq : 'z;

    sdram_ctrl_top #(.POWERUP_CYC(PWR), .REFRESH_INTERVAL(RINT), .CAS_LAT(CASL)) dut_i (
        .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data), .rd_ready(rd_ready),
        .busy(busy), .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dq(sd_dq), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_dqm_lo(sd_dqm_lo), .sd_dqm_hi(sd_dqm_hi)
    );

    int n_chk = 0, n_bad = 0;
    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input logic [23:0] a);
        return a[15:0] ^ {a[23:16], a[7:0]} ^ 16'h5A3C;
    endfunction

    // ---------------- behavioural memory ----------------
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [15:0] mem [int unsigned];
    bit          open_b [4];
    logic [12:0] orow [4];
    int          t_act [4];
    int          t_pre = -100;
    int          ncmd = 0, first_cyc = -1, rel_cyc = 0;
    logic [3:0]  seq [4];
    logic [12:0] mrs_a = '0, pre0_a = '0;
    logic [1:0]  mrs_ba = '1;
    logic [3:0]  last_cmd = C_NOP, last_col = C_NOP;
    int          n_wr = 0, n_rd = 0, n_ref = 0, last_ref = -1;
    int          min_iv = 1 << 30, max_iv = 0;
    int          rd_cnt = 0;
    logic [15:0] rd_val = '0;
    logic [23:0] last_key = '0;

    initial for (int i = 0; i < 4; i++) t_act[i] = -100;

    always @(negedge clk) begin
        logic [3:0] c;
        logic [23:0] key;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (m_oe) m_oe = 1'b0;
        if (rd_cnt > 0) begin
            rd_cnt--;
            if (rd_cnt == 0) begin m_oe = 1'b1; m_dq = rd_val; end
        end
        if (!rst && c != C_NOP) begin
            if (ncmd < 4) seq[ncmd] = c;
            if (ncmd == 0) begin first_cyc = cyc; pre0_a = sd_addr; end
            ncmd++;
            case (c)
                C_PRE: begin
                    if (sd_addr[10]) for (int i = 0; i < 4; i++) open_b[i] = 0;
                    else open_b[sd_ba] = 0;
                    t_pre = cyc;
                end
                C_REF: begin
                    check(!open_b[0] && !open_b[1] && !open_b[2] && !open_b[3], "R12", "REF with open bank", 1, 0);
                    check(cyc - t_pre >= 2, "R12", "PRE to REF gap", cyc - t_pre, 2);
                    if (ncmd > 4) begin
                        check(last_cmd == C_PRE, "R10", "command before REF", last_cmd, C_PRE);
                        n_ref++;
                        if (last_ref >= 0) begin
                            if (cyc - last_ref < min_iv) min_iv = cyc - last_ref;
                            if (cyc - last_ref > max_iv) max_iv = cyc - last_ref;
                        end
                        last_ref = cyc;
                    end
                end
                C_MRS: begin mrs_a = sd_addr; mrs_ba = sd_ba; end
                C_ACT: begin
                    check(!open_b[sd_ba], "R12", "ACT to open bank", 1, 0);
                    check(cyc - t_pre >= 2, "R12", "PRE to ACT gap", cyc - t_pre, 2);
                    check(cyc - t_act[sd_ba] >= 7, "R12", "ACT to ACT gap", cyc - t_act[sd_ba], 7);
                    open_b[sd_ba] = 1; orow[sd_ba] = sd_addr; t_act[sd_ba] = cyc;
                end
                C_RD, C_WR: begin
                    check(open_b[sd_ba], "R12", "column to closed bank", 0, 1);
                    check(cyc - t_act[sd_ba] >= 2, "R12", "ACT to column gap", cyc - t_act[sd_ba], 2);
                    check(sd_addr[10], "R3", "auto-precharge bit", sd_addr[10], 1);
                    key = {sd_ba, orow[sd_ba], sd_addr[8:0]};
                    last_key = key;
                    open_b[sd_ba] = 0;
                    last_col = c;
                    if (c == C_WR) begin
                        check(!sd_dqm_lo && !sd_dqm_hi, "R4", "byte masks in write", {sd_dqm_hi, sd_dqm_lo}, 0);
                        mem[key] = sd_dq;
                        n_wr++;
                    end else begin
                        rd_val = mem.exists(key) ? mem[key] : 16'hDEAD;
                        rd_cnt = CASL;
                        n_rd++;
                    end
                end
                default: check(0, "R12", "illegal command", c, C_NOP);
            endcase
            last_cmd = c;
        end
    end

    // ---------------- host tasks ----------------
    task automatic do_write(input logic [23:0] a, input logic [15:0] d, output int blen);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        while (!busy) @(negedge clk);
        wr_en = 1'b0;
        blen = 0;
        while (busy) begin blen++; @(negedge clk); end
    endtask

    task automatic do_read(input logic [23:0] a, output logic [15:0] d,
                           output int pulses, output int blen);
        @(negedge clk);
        rd_addr = a; rd_en = 1'b1;
        while (!busy) @(negedge clk);
        rd_en = 1'b0;
        pulses = 0; blen = 0; d = 'x;
        while (busy) begin
            if (rd_ready) begin pulses++; d = rd_data; end
            blen++;
            @(negedge clk);
        end
        if (rd_ready) pulses++;
    endtask

    function automatic logic [23:0] sweep_addr(input int b, input int r, input int c);
        logic [12:0] row;
        logic [8:0]  col;
        row = (r == 0) ? 13'h0000 : (r == 1) ? 13'h0001 : 13'h1FFF;
        col = (c == 0) ? 9'h000 : (c == 1) ? 9'h0AA : 9'h1FF;
        return {b[1:0], row, col};
    endfunction

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "ALL", "watchdog expired", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        logic [15:0] d;
        int pulses, blen, w0, r0;
        logic [3:0] c;

        // R1: reset state
        repeat (4) @(negedge clk);
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        check(c == C_NOP, "R1", "command in reset", c, C_NOP);
        check(!sd_cke, "R1", "cke in reset", sd_cke, 0);
        check(!busy && !rd_ready, "R1", "busy/rd_ready in reset", {busy, rd_ready}, 0);
        rst = 1'b0; rel_cyc = cyc;
        while (ncmd < 4) @(negedge clk);
        repeat (12) @(negedge clk);
        check(first_cyc - rel_cyc >= PWR, "R1", "power-up NOP span", first_cyc - rel_cyc, PWR);
        check(sd_cke, "R1", "cke after reset", sd_cke, 1);

        // R2: init order and mode word
        check(seq[0] == C_PRE && pre0_a[10], "R2", "first command PRE-all", {seq[0], 3'b0, pre0_a[10]}, {C_PRE, 4'h1});
        check(seq[1] == C_REF, "R2", "second command", seq[1], C_REF);
        check(seq[2] == C_REF, "R2", "third command", seq[2], C_REF);
        check(seq[3] == C_MRS, "R2", "fourth command", seq[3], C_MRS);
        check(mrs_a == 13'h230 && mrs_ba == 2'b00, "R2", "mode word", {mrs_ba, mrs_a}, 15'h0230);

        // R3/R4/R6: write sweep
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 3; r++)
                for (int k = 0; k < 3; k++) begin
                    logic [23:0] a;
                    a = sweep_addr(b, r, k);
                    do_write(a, pat(a), blen);
                    check(last_key == a, "R3", "write address split", last_key, a);
                    check(mem.exists(a) && mem[a] == pat(a), "R4", "word stored", mem.exists(a) ? mem[a] : 16'hDEAD, pat(a));
                    check(blen == 8, "R6", "write busy length", blen, 8);
                end

        // R5/R6: read sweep
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 3; r++)
                for (int k = 0; k < 3; k++) begin
                    logic [23:0] a;
                    a = sweep_addr(b, r, k);
                    do_read(a, d, pulses, blen);
                    check(d == pat(a), "R5", "read data", d, pat(a));
                    check(pulses == 1, "R5", "rd_ready pulses in busy", pulses, 1);
                    check(blen == 9, "R6", "read busy length", blen, 9);
                end

        // R7: inputs changed while busy are ignored
        begin
            logic [23:0] p, q;
            p = sweep_addr(1, 1, 1); q = sweep_addr(2, 2, 2);
            @(negedge clk);
            wr_addr = p; wr_data = 16'hBEEF; wr_en = 1'b1;
            while (!busy) @(negedge clk);
            wr_en = 1'b0; wr_addr = q; wr_data = 16'h1234;
            while (busy) @(negedge clk);
            do_read(p, d, pulses, blen);
            check(d == 16'hBEEF, "R7", "latched write data", d, 16'hBEEF);
            do_read(q, d, pulses, blen);
            check(d == pat(q), "R7", "untouched address", d, pat(q));
        end

        // R8: enable held high gives another access
        @(negedge clk);
        w0 = n_wr;
        wr_addr = sweep_addr(3, 0, 0); wr_data = 16'h0F0F; wr_en = 1'b1;
        for (int i = 0; i < 80 && n_wr < w0 + 2; i++) @(negedge clk);
        wr_en = 1'b0;
        while (busy) @(negedge clk);
        check(n_wr - w0 >= 2, "R8", "writes from held enable", n_wr - w0, 2);

        // R9: read wins over write
        @(negedge clk);
        w0 = n_wr;
        rd_addr = sweep_addr(0, 2, 1); wr_addr = sweep_addr(0, 0, 2); wr_data = 16'hAAAA;
        rd_en = 1'b1; wr_en = 1'b1;
        while (!busy) @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        while (busy) @(negedge clk);
        check(n_wr == w0, "R9", "write count with both enables", n_wr - w0, 0);
        check(last_col == C_RD, "R9", "column command served", last_col, C_RD);

        // R11: continuous reads do not starve refresh
        @(negedge clk);
        r0 = n_ref;
        rd_addr = sweep_addr(2, 1, 0); rd_en = 1'b1;
        repeat (3000) @(negedge clk);
        rd_en = 1'b0;
        while (busy) @(negedge clk);
        check(n_ref - r0 >= 6, "R11", "refreshes under load", n_ref - r0, 6);

        // R10: refresh spacing
        repeat (800) @(negedge clk);
        check(n_ref >= 8, "R10", "refresh count", n_ref, 8);
        check(min_iv >= RINT - 20, "R10", "minimum refresh spacing", min_iv, RINT - 20);
        check(max_iv <= RINT + 20, "R10", "maximum refresh spacing", max_iv, RINT + 20);

        summary();
        $finish;
    end
endmodule